// File: doc/BRIEF.md
# Chained DMA Channel (Device-to-Memory)

This block is one receive channel of a chained DMA engine. Software sets it up through a small bank of 32-bit registers. The bank holds a command/status word, a running pointer, a limit, a reload start and stop pair, a one-shot buffer pointer, the saved copies of the running pointer and limit, and the rounded size of the last burst. An attached device announces a burst by giving its byte count. The channel then pulls the data words from the device and writes them to memory, one 32-bit word per cycle, through a valid/ready port.

Each burst is padded up to the channel's alignment granule, and the padding words are written as zero. The destination is the one-shot buffer pointer if that pointer is nonzero; otherwise it is the running pointer. When the last word has been accepted, the channel finishes in a single step:

- it records where the burst went;
- it clears the one-shot pointer;
- it reloads the running pointer and limit from the start/stop pair, unless software has asked to update them itself;
- it sets the complete flag and emits a one-cycle interrupt pulse.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset, every register reads zero, and `busy` and `irq` are low.
- R2: A write to offset 0x0000 is a command word, not a plain store. Bit 16 sets enable (status bit 0), bit 17 sets self-update (status bit 1), bit 20 sets direction (status bit 2), and bit 18 clears complete (status bit 3). A zero command bit leaves its status bit unchanged. Status bits 31..4 read zero.
- R3: Command bit 19 clears enable, self-update, direction and complete together. It wins over any set bit in the same word.
- R4: These registers store and read back 32-bit values: next at 0x4000, limit at 0x4004, start at 0x4008, stop at 0x400C and one-shot at 0x4200. Saved-next at 0x4010, saved-limit at 0x4014 and size at 0x4204 are read-only. Any other offset reads zero.
- R5: A `burst_start` pulse is accepted only when enable is set and the channel is idle. Otherwise it is ignored: no memory write occurs and `busy` stays as it was.
- R6: The burst length is rounded up to a multiple of ALIGN_BYTES (default 16). The rounded length divided by 4 gives the number of words written, at consecutive word addresses. The first ceil(bytes/4) words carry device data, and the remaining words are zero. A zero-byte burst writes nothing but still completes.
- R7: The base address is the one-shot pointer when that pointer is nonzero, and next otherwise. The one-shot pointer reads zero after the burst.
- R8: After a burst, saved-next equals next as it was before the burst, saved-limit equals that value plus the rounded length, and size equals the rounded length.
- R9: When self-update is clear at completion, next is reloaded from start and limit from stop. When self-update is set, next and limit are unchanged.
- R10: At completion, complete (status bit 3) becomes set in the same cycle that `irq` goes high. `irq` stays high for exactly one cycle per burst, and `busy` is low in that cycle.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, decoded from `reg_addr` |
| burst_start | input | 1 | Device announces a burst |
| burst_bytes | input | BCW | Burst length in bytes |
| dev_valid | input | 1 | Device data word available |
| dev_data | input | 32 | Device data word |
| dev_ready | output | 1 | Channel takes the device word this cycle |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word byte address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| busy | output | 1 | Burst in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on two things from the device and memory sides:

- Once the device raises `dev_valid`, it keeps `dev_valid` high and keeps `dev_data` constant until the word is taken.
- The memory side may stall for any number of cycles.

The stimulus keeps `dev_valid` high for the whole run and changes `dev_data` only after a handshake. It stalls `mem_ready` only in the hold test. Bursts are issued only at negative edges, and the length is held steady while `burst_start` is high.

// File: rtl/dma_chain_chan.sv
`timescale 1ns/1ps
module dma_chain_chan #(
  parameter int AW = 32,
  parameter int BCW = 16,
  parameter int ALIGN_BYTES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [15:0]    reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           burst_start,
  input  logic [BCW-1:0] burst_bytes,
  input  logic           dev_valid,
  input  logic [31:0]    dev_data,
  output logic           dev_ready,
  output logic           mem_valid,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_data,
  input  logic           mem_ready,
  output logic           busy,
  output logic           irq
);
  localparam int WW = BCW - 1;
  localparam logic [BCW:0] AMSK = (BCW+1)'(ALIGN_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;
  st_t st;

  logic en, supd, dir, cmpl;
  logic [AW-1:0] nxt, lim, strt, stp, ob, sv_nxt, sv_lim, sz, base;
  logic [WW-1:0] idx, tot, dw;

  logic [BCW:0] ext, rnd, ext3;
  assign ext  = {1'b0, burst_bytes};
  assign rnd  = (ext + AMSK) & ~AMSK;
  assign ext3 = ext + (BCW+1)'(3);

  logic accept, in_data, step, last;
  assign accept    = burst_start && st == S_IDLE && en;
  assign in_data   = idx < dw;
  assign mem_valid = st == S_XFER && (in_data ? dev_valid : 1'b1);
  assign mem_data  = in_data ? dev_data : 32'h0;
  assign mem_addr  = base + AW'({idx, 2'b00});
  assign dev_ready = st == S_XFER && in_data && mem_ready;
  assign step      = mem_valid && mem_ready;
  assign last      = (idx + 1'b1) == tot;
  assign busy      = st != S_IDLE;

  always_comb begin
    case (reg_addr)
      16'h0000: reg_rdata = {28'h0, cmpl, dir, supd, en};
      16'h4000: reg_rdata = 32'(nxt);
      16'h4004: reg_rdata = 32'(lim);
      16'h4008: reg_rdata = 32'(strt);
      16'h400C: reg_rdata = 32'(stp);
      16'h4010: reg_rdata = 32'(sv_nxt);
      16'h4014: reg_rdata = 32'(sv_lim);
      16'h4200: reg_rdata = 32'(ob);
      16'h4204: reg_rdata = 32'(sz);
      default:  reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; irq <= 1'b0;
      {en, supd, dir, cmpl} <= 4'h0;
      nxt <= '0; lim <= '0; strt <= '0; stp <= '0; ob <= '0;
      sv_nxt <= '0; sv_lim <= '0; sz <= '0; base <= '0;
      idx <= '0; tot <= '0; dw <= '0;
    end else begin
      irq <= st == S_DONE;
      if (reg_we) begin
        case (reg_addr)
          16'h0000: begin
            if (reg_wdata[16]) en   <= 1'b1;
            if (reg_wdata[17]) supd <= 1'b1;
            if (reg_wdata[20]) dir  <= 1'b1;
            if (reg_wdata[18]) cmpl <= 1'b0;
            if (reg_wdata[19]) {en, supd, dir, cmpl} <= 4'h0;
          end
          16'h4000: nxt  <= AW'(reg_wdata);
          16'h4004: lim  <= AW'(reg_wdata);
          16'h4008: strt <= AW'(reg_wdata);
          16'h400C: stp  <= AW'(reg_wdata);
          16'h4200: ob   <= AW'(reg_wdata);
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (accept) begin
          base <= (ob != '0) ? ob : nxt;
          sz   <= AW'(rnd);
          tot  <= rnd[BCW:2];
          dw   <= ext3[BCW:2];
          idx  <= '0;
          st   <= (rnd == '0) ? S_DONE : S_XFER;
        end
        S_XFER: if (step) begin
          idx <= idx + 1'b1;
          if (last) st <= S_DONE;
        end
        default: begin
          ob     <= '0;
          sv_nxt <= nxt;
          sv_lim <= nxt + sz;
          if (!supd) begin
            nxt <= strt;
            lim <= stp;
          end
          cmpl <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_cmpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmpl && !busy));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  p_oneshot_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ob == '0));
  p_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !en) |=> (st == S_IDLE));
endmodule

// File: tb/dma_chain_chan_tb.sv
`timescale 1ns/1ps
module dma_chain_chan_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [15:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic burst_start = 0;
  logic [15:0] burst_bytes = 0;
  logic dev_ready, mem_valid, busy, irq;
  logic [31:0] mem_addr, mem_data, dev_data;
  logic mem_ready = 1;
  int checks = 0, fails = 0;
  int wn = 0, dk = 0, irqn = 0;
  logic [31:0] wa [0:63];
  logic [31:0] wd [0:63];

  always #5 clk = ~clk;
  assign dev_data = 32'hA500_0000 + dk;

  dma_chain_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .burst_start(burst_start),
    .burst_bytes(burst_bytes), .dev_valid(1'b1), .dev_data(dev_data),
    .dev_ready(dev_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready), .busy(busy), .irq(irq));

  always @(posedge clk) begin
    if (mem_valid && mem_ready && wn < 64) begin
      wa[wn] <= mem_addr; wd[wn] <= mem_data; wn <= wn + 1;
    end
    if (dev_ready) dk <= dk + 1;
    if (irq) irqn <= irqn + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rchk(string req, logic [15:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic burst(int bytes);
    @(negedge clk); burst_start = 1; burst_bytes = 16'(bytes);
    @(negedge clk); burst_start = 0;
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    chk("R10 irq at busy fall", {31'b0, irq}, 1);
    chk("R10 complete with irq", {31'b0, reg_addr == 16'h0 ? reg_rdata[3] : 1'b1}, 1);
    @(negedge clk);
    chk("R10 irq one cycle", {31'b0, irq}, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    foreach (wa[i]) if (i < 9) begin
      logic [15:0] offs [0:8];
      offs = '{16'h0, 16'h4000, 16'h4004, 16'h4008, 16'h400C, 16'h4010, 16'h4014, 16'h4200, 16'h4204};
      rchk("R1 reset reg", offs[i], 0);
    end
  endtask

  task automatic t_csr;
    wr(16'h0, 32'h0001_0000); rchk("R2 set enable", 16'h0, 32'h1);
    wr(16'h0, 32'h0010_0000); rchk("R2 set direction", 16'h0, 32'h5);
    wr(16'h0, 32'h0002_0000); rchk("R2 set self-update", 16'h0, 32'h7);
    wr(16'h0, 32'h0000_FFFF); rchk("R2 zero command no effect", 16'h0, 32'h7);
    wr(16'h0, 32'h0009_0000); rchk("R3 reset wins", 16'h0, 32'h0);
  endtask

  task automatic t_regs;
    wr(16'h4000, 32'h1000); wr(16'h4004, 32'h1100);
    wr(16'h4008, 32'h2000); wr(16'h400C, 32'h2100);
    wr(16'h4200, 32'h0);
    rchk("R4 next", 16'h4000, 32'h1000);
    rchk("R4 limit", 16'h4004, 32'h1100);
    rchk("R4 start", 16'h4008, 32'h2000);
    rchk("R4 stop", 16'h400C, 32'h2100);
    wr(16'h4204, 32'h55); rchk("R4 size read-only", 16'h4204, 0);
    wr(16'h4010, 32'h77); rchk("R4 saved-next read-only", 16'h4010, 0);
    rchk("R4 unmapped", 16'h0008, 0);
  endtask

  task automatic t_disabled;
    int w0 = wn;
    @(negedge clk); burst_start = 1; burst_bytes = 8;
    @(negedge clk); burst_start = 0;
    repeat (4) @(negedge clk);
    chk("R5 disabled busy", {31'b0, busy}, 0);
    chk("R5 disabled no writes", 32'(wn - w0), 0);
    rchk("R5 disabled no complete", 16'h0, 0);
  endtask

  task automatic t_chain;
    int w0 = wn, d0 = dk, q0 = irqn;
    wr(16'h0, 32'h0001_0000);
    reg_addr = 16'h0;
    burst(20);
    chk("R6 word count 20B", 32'(wn - w0), 8);
    for (int i = 0; i < 8; i++) begin
      chk("R7 base next addr", wa[w0+i], 32'h1000 + 4*i);
      chk("R6 data/pad", wd[w0+i], i < 5 ? 32'hA500_0000 + d0 + i : 0);
    end
    chk("R10 one irq", 32'(irqn - q0), 1);
    rchk("R8 saved-next", 16'h4010, 32'h1000);
    rchk("R8 saved-limit", 16'h4014, 32'h1020);
    rchk("R8 size", 16'h4204, 32'd32);
    rchk("R9 reload next", 16'h4000, 32'h2000);
    rchk("R9 reload limit", 16'h4004, 32'h2100);
    rchk("R10 complete", 16'h0, 32'h9);
  endtask

  task automatic t_oneshot;
    int w0 = wn;
    wr(16'h0, 32'h0006_0000);
    rchk("R2 clear complete", 16'h0, 32'h3);
    wr(16'h4200, 32'h3000);
    reg_addr = 16'h0;
    burst(16);
    chk("R6 exact multiple", 32'(wn - w0), 4);
    chk("R7 one-shot base", wa[w0], 32'h3000);
    chk("R7 one-shot last", wa[w0+3], 32'h300C);
    rchk("R7 one-shot cleared", 16'h4200, 0);
    rchk("R9 no reload next", 16'h4000, 32'h2000);
    rchk("R9 no reload limit", 16'h4004, 32'h2100);
    rchk("R8 saved-next", 16'h4010, 32'h2000);
    rchk("R8 saved-limit", 16'h4014, 32'h2010);
  endtask

  task automatic t_stall;
    int w0 = wn, d0 = dk, q0 = irqn;
    logic [31:0] a1;
    mem_ready = 0;
    @(negedge clk); burst_start = 1; burst_bytes = 4;
    @(negedge clk); burst_start = 0;
    @(negedge clk);
    chk("R11 valid while stalled", {31'b0, mem_valid}, 1);
    a1 = mem_addr;
    burst_start = 1; burst_bytes = 40;
    @(negedge clk); burst_start = 0;
    chk("R11 addr held", mem_addr, a1);
    chk("R11 valid held", {31'b0, mem_valid}, 1);
    chk("R5 busy during burst", {31'b0, busy}, 1);
    mem_ready = 1;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R5 second start ignored", 32'(wn - w0), 4);
    chk("R11 first addr", wa[w0], 32'h2000);
    chk("R6 short burst data", wd[w0], 32'hA500_0000 + d0);
    chk("R6 short burst pad", wd[w0+1], 0);
    chk("R10 irq per burst", 32'(irqn - q0), 1);
  endtask

  task automatic t_zero;
    int w0 = wn;
    wr(16'h0, 32'h0004_0000);
    reg_addr = 16'h0;
    burst(0);
    chk("R6 zero bytes no writes", 32'(wn - w0), 0);
    rchk("R8 zero size", 16'h4204, 0);
    rchk("R8 zero saved-limit", 16'h4014, 32'h2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_csr; t_regs; t_disabled; t_chain; t_oneshot; t_stall; t_zero;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule